// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an eight-pin bidirectional general-purpose port. It holds an output data latch and a per-pin direction register, where a 1 makes the pin an input. It drives three pad control vectors: output enable, output value and weak pull-up enable. Software reaches it over a small register bus. A read of the data register returns the pin levels after synchronization. A read or a write of that register also takes a snapshot of those levels.

The upper pins (bits 7 down to 4) watch for change. Each of them that is set as an input is compared with the snapshot. If any one differs, a sticky change flag is raised and a registered wake request is asserted, which a sleeping system can use. The mismatch lasts until software next reads or writes the data register. Bit 0 also serves as an external interrupt input, and a control bit sets whether a rising or a falling edge raises its flag. Every pin passes through a two-stage synchronizer before it is used.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset every pin is an input (direction reads 0xFF), the output latch is 0, `pad_oe` and `pad_pu` are 0, the control register reads 0x03, and `chg_irq`, `ext_irq` and `wake` are low.
- R2: The register map is: address 0 is port data, address 1 is direction, address 2 is control. A write to address 0 sets `pad_out`, and a write to address 1 sets `pad_oe` to the inverse of the written direction. Both take effect on the clock edge that accepts the write.
- R3: The control bit 0 is the active-low pull-up enable. `pad_pu[i]` is high only when control bit 0 is 0 and pin i is an input. An output pin never has its pull-up on.
- R4: A read has its result in `bus_rdata` one cycle after it is accepted. A read of address 0 returns the synchronized pin levels, so a pin change shows up in a read accepted two or more clocks after the change.
- R5: Only pins 7 to 4 take part in change detection, and only while they are inputs. A change on pins 3 to 0, or on an upper pin set as an output, leaves `chg_irq` low.
- R6: The change flag (control bit 2, and `chg_irq`) is set on every cycle in which a mismatch exists. A write of 0 to it in such a cycle does not clear it.
- R7: A read or a write of address 0 reloads the snapshot from the synchronized pins, which ends the mismatch.
- R8: Control bit 1 selects the edge of pin 0 that sets the external flag (control bit 3, and `ext_irq`): 1 selects rising and 0 selects falling. The opposite edge has no effect.
- R9: `wake` is high in the cycle after any cycle that has a mismatch. It falls one cycle after the snapshot reload that ends the mismatch, while `chg_irq` stays set.
- R10: A read of address 2 returns the pull-up bit in bit 0, the edge select in bit 1, the change flag in bit 2 and the external flag in bit 3. All other bits read 0.
- R11: A write to address 2 with 0 in a flag bit clears that flag when its set condition is absent. Writing 1 to a flag bit never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| chg_irq | output | 1 | Sticky change-detected flag |
| ext_irq | output | 1 | Sticky pin-0 edge flag |
| wake | output | 1 | Wake request while a mismatch exists |

## Verification
Register writes reach the pad outputs on the clock edge that accepts them, so the bench checks the pads at the falling edge that follows. Read data appears one cycle after the read is accepted. The scoreboard monitor takes each expected item off its queue at the falling edge after the accepting rising edge. A pin change passes through two synchronizer edges and one flag edge, so `chg_irq`, `wake` and `ext_irq` are due three rising edges after the stimulus, and the bench waits exactly that long. `wake` falls one edge after the reload that clears the mismatch, so it is sampled one cycle after the access completes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_CTRL = 2'd2
  } reg_sel_e;

  localparam int CB_PULLN = 0;
  localparam int CB_RISE  = 1;
  localparam int CB_CHG   = 2;
  localparam int CB_EXT   = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int W  = 8,
  parameter int LO = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] dir_in,
  input  logic         reload,
  output logic         mismatch
);
  localparam logic [W-1:0] WATCH = {W{1'b1}} << LO;

  logic [W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst)         snap <= '0;
    else if (reload) snap <= pin_s;
  end

  assign mismatch = |((pin_s ^ snap) & dir_in & WATCH);
endmodule

// File: rtl/gpio_ext_edge.sv
module gpio_ext_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic rise_sel,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign hit = rise_sel ? (level & ~prev) : (~level & prev);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int WIDTH       = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_BIT     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu,
  output logic             chg_irq,
  output logic             ext_irq,
  output logic             wake
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] out_q, dir_q, rdata_q, pin_s, ctrl_vec;
  logic pulln_q, rise_q, chg_q, ext_q, wake_q;
  logic mismatch, edge_hit;
  logic wr_data, wr_dir, wr_ctrl, port_acc;

  assign wr_data  = bus_sel & bus_wr & (bus_addr == REG_DATA);
  assign wr_dir   = bus_sel & bus_wr & (bus_addr == REG_DIR);
  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == REG_CTRL);
  assign port_acc = bus_sel & (bus_wr | bus_rd) & (bus_addr == REG_DATA);

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  gpio_chg_detect #(.W(WIDTH), .LO(CHG_LO)) u_chg (
    .clk(clk), .rst(rst), .pin_s(pin_s), .dir_in(dir_q),
    .reload(port_acc), .mismatch(mismatch)
  );

  gpio_ext_edge u_ext (
    .clk(clk), .rst(rst), .level(pin_s[EXT_BIT]),
    .rise_sel(rise_q), .hit(edge_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '1;
      pulln_q <= 1'b1;
      rise_q  <= 1'b1;
    end else begin
      if (wr_data) out_q <= bus_wdata;
      if (wr_dir)  dir_q <= bus_wdata;
      if (wr_ctrl) begin
        pulln_q <= bus_wdata[CB_PULLN];
        rise_q  <= bus_wdata[CB_RISE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q  <= 1'b0;
      ext_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= mismatch;
      if (mismatch)                          chg_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CB_CHG]) chg_q <= 1'b0;
      if (edge_hit)                          ext_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CB_EXT]) ext_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_vec           = '0;
    ctrl_vec[CB_PULLN] = pulln_q;
    ctrl_vec[CB_RISE]  = rise_q;
    ctrl_vec[CB_CHG]   = chg_q;
    ctrl_vec[CB_EXT]   = ext_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_sel && bus_rd) begin
      case (bus_addr)
        REG_DATA: rdata_q <= pin_s;
        REG_DIR:  rdata_q <= dir_q;
        REG_CTRL: rdata_q <= ctrl_vec;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_oe    = ~dir_q;
  assign pad_out   = out_q;
  assign pad_pu    = dir_q & {WIDTH{~pulln_q}};
  assign chg_irq   = chg_q;
  assign ext_irq   = ext_q;
  assign wake      = wake_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pu,
  input logic             chg_irq,
  input logic             wake
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_pu == '0 && pad_out == '0 && !chg_irq && !wake));

  p_pad_out_write_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pad_out) |-> $past(bus_sel && bus_wr && bus_addr == 2'd0));

  p_pu_out_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pu) == '0);

  p_wake_flag_r6: assert property (@(posedge clk) disable iff (rst)
    wake |-> chg_irq);

  p_chg_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(chg_irq) |-> (!wake && $past(bus_sel && bus_wr && bus_addr == 2'd2 && !bus_wdata[2])));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pu(pad_pu), .chg_irq(chg_irq), .wake(wake)
);

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic [7:0] bus_rdata, pad_oe, pad_out, pad_pu;
  logic       chg_irq, ext_irq, wake;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  gpio_chg_port u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .chg_irq(chg_irq), .ext_irq(ext_irq), .wake(wake)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: issues the read and queues the expected item
  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  // monitor: read data is due one cycle after the accepting edge
  always @(posedge clk) rd_seen <= bus_sel && bus_rd && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 flags", {5'b0, chg_irq, ext_irq, wake}, 8'h00);
    bus_read(2'd1, 8'hFF, "R1 dir reset");
    bus_read(2'd2, 8'h03, "R1 R10 ctrl reset");
    bus_read(2'd0, 8'h00, "R4 pins idle");

    // pull-ups on, rising edge
    bus_write(2'd2, 8'h02);
    check("R3 pu all inputs", pad_pu, 8'hFF);
    bus_write(2'd1, 8'h3C);
    check("R2 oe from dir", pad_oe, 8'hC3);
    check("R3 pu masked by outputs", pad_pu, 8'h3C);
    bus_write(2'd0, 8'hA5);
    check("R2 out latch", pad_out, 8'hA5);

    // change on an output-configured upper pin
    pin_in = 8'h80; tick(3);
    check("R5 output pin ignored", {7'b0, chg_irq}, 8'h00);
    // change on a lower input pin
    pin_in = 8'h84; tick(3);
    check("R5 lower pin ignored", {7'b0, chg_irq}, 8'h00);
    // change on an upper input pin
    pin_in = 8'hA4; tick(3);
    check("R5 upper input sets flag", {7'b0, chg_irq}, 8'h01);
    check("R9 wake on mismatch", {7'b0, wake}, 8'h01);

    // clear attempt while mismatch persists
    bus_write(2'd2, 8'h02);
    tick(1);
    check("R6 clear ignored during mismatch", {7'b0, chg_irq}, 8'h01);
    bus_read(2'd2, 8'h06, "R10 R6 ctrl shows flag");

    // read reloads snapshot (bus_read already waited one cycle)
    bus_read(2'd0, 8'hA4, "R4 R7 port read");
    check("R9 wake drops after reload", {7'b0, wake}, 8'h00);
    check("R6 flag sticky after reload", {7'b0, chg_irq}, 8'h01);
    bus_write(2'd2, 8'h02);
    check("R11 clear with 0", {7'b0, chg_irq}, 8'h00);
    bus_write(2'd2, 8'h06);
    tick(1);
    check("R11 writing 1 no set", {7'b0, chg_irq}, 8'h00);

    // write to port data also reloads
    pin_in = 8'hB4; tick(3);
    check("R5 second upper input", {7'b0, chg_irq}, 8'h01);
    bus_write(2'd0, 8'hA5);
    tick(1);
    check("R7 write reload ends wake", {7'b0, wake}, 8'h00);
    bus_write(2'd2, 8'h02);
    check("R7 R11 clear after write reload", {7'b0, chg_irq}, 8'h00);

    // external edge, rising mode
    pin_in = 8'hB5; tick(3);
    check("R8 rising edge sets", {7'b0, ext_irq}, 8'h01);
    bus_write(2'd2, 8'h02);
    check("R11 ext clear", {7'b0, ext_irq}, 8'h00);
    pin_in = 8'hB4; tick(3);
    check("R8 falling ignored in rising mode", {7'b0, ext_irq}, 8'h00);
    // falling mode
    bus_write(2'd2, 8'h00);
    pin_in = 8'hB5; tick(3);
    check("R8 rising ignored in falling mode", {7'b0, ext_irq}, 8'h00);
    pin_in = 8'hB4; tick(3);
    check("R8 falling edge sets", {7'b0, ext_irq}, 8'h01);
    bus_read(2'd2, 8'h08, "R10 ctrl ext flag");

    // pull-ups off
    bus_write(2'd2, 8'h09);
    check("R3 pu off", pad_pu, 8'h00);
    check("R11 ext kept by 1", {7'b0, ext_irq}, 8'h01);

    tick(2);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R4 reads not returned actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule